// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a serial control-port slave. An external host uses it to read and write a small bank of 8-bit configuration registers over three pins: an active-low select, a serial clock, and one data line that both sides share. The block drives the data line only while it returns read data. Every frame opens with a 16-bit instruction that carries a direction bit, a two-bit length code and a 13-bit register address. Data bytes follow the instruction. The address counts down by one after each byte, so a single frame can reach a run of adjacent registers.

All three pins pass through two-flop synchronizers into the system clock domain. The block finds serial clock edges by comparing successive synchronized samples. When the select pin is high as reset is released, the port is never enabled and a strap flag is raised instead. The register contents appear on a flat output bus for the surrounding logic.

There is no back-pressure anywhere. The host sets the pace of the bus, so the pins carry no ready signal. Inside the block, the write path from the frame engine to the bank uses valid only, because the bank accepts a byte in every cycle. A byte that is presented is always taken.

Top module: `spi3_regport`

## Requirements
- R1: A frame begins when the select falls. The first sampled bit is the direction (1 = read, 0 = write). Two length bits follow, the upper one first, then address bits 12 down to 0. Every serial clock level must last at least three system clock periods, and the data line must stay stable across each rising edge.
- R2: Data bits are taken on serial clock rising edges, most significant bit first. A write byte reaches the bank only after its eighth bit has been sampled.
- R3: Length codes 00, 01 and 10 move one, two and three bytes. Serial clock pulses after the last byte have no effect on any register.
- R4: Length code 11 streams bytes until the select rises.
- R5: After each completed byte the address decreases by one, wrapping from 0 to 8191.
- R6: The data line output enable stays low during the instruction and throughout write frames. In a read frame it rises only on a serial clock falling edge after the instruction is complete, and each bit is presented most significant bit first.
- R7: In a read of fixed length, the output enable falls on the serial clock rising edge that samples bit 0 of the final byte.
- R8: When the select rises at any point, the frame is abandoned. The output enable drops, the bit count restarts, and a partly shifted write byte is discarded.
- R9: Registers live at addresses 0 to NUM_REGS-1. Writes to any other address change nothing, and reads from them return 0x00.
- R10: If the select is high when reset is released, strap_mode reads 1 and the port ignores all pin activity, so the output enable stays low until the next reset.
- R11: After reset, every register reads 0x00 and the output enable is low. If the select was low at reset release, strap_mode reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low frame select pin |
| spi_sclk | input | 1 | Serial clock pin |
| spi_sdio_i | input | 1 | Data line input path |
| spi_sdio_o | output | 1 | Data line output value |
| spi_sdio_oe | output | 1 | Data line output enable |
| strap_mode | output | 1 | Port disabled, pins treated as static straps |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i at bits 8i+7:8i |

## Verification
Several rules hold in every cycle, and assertions check them there:
- the output enable rises only after a synchronized falling edge;
- the output enable falls only on a rising edge or an abort;
- a raised select clears the frame on the next cycle;
- the output enable is never set during a write;
- a write to an unmapped address leaves the register bus unchanged;
- strap mode never drives the line.

Other behaviour can only be shown by whole frames in the bench. These scenarios cover:
- the bit order of the instruction and of the data;
- the length codes and streaming;
- the downward address walk and its wrap past zero;
- the read data values;
- a partial byte discarded after an abort;
- the strap decision made at reset release.

// File: rtl/spi3_pkg.sv
package spi3_pkg;

  // frame engine phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INSTR = 2'd1,
    PH_DATA  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  // length code that keeps the frame open until select rises
  localparam logic [1:0] LEN_STREAM = 2'b11;

  // bit positions inside the synchronized pin vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDIO = 2;
  localparam int PIN_N    = 3;

endpackage

// File: rtl/spi3_pinsync.sv
module spi3_pinsync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
        prev_q <= RST_VAL[i];
      end else begin
        meta_q <= pin_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign sync_o[i] = sync_q;
    assign prev_o[i] = prev_q;
  end

endmodule

// File: rtl/spi3_regbank.sv
module spi3_regbank #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int BASE     = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_REGS*DATA_W-1:0]   cfg_flat
);

  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [ADDR_W-1:0] wr_idx, rd_idx;

  assign wr_idx = wr_addr - BASE_A;
  assign rd_idx = rd_addr - BASE_A;

  // an index beyond LAST_IDX matches no register, so the write falls away
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_valid) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_idx == ADDR_W'(i)) regs[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == ADDR_W'(i)) rd_data = regs[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign cfg_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  // R9: a write outside the map leaves every register untouched
  p_unmapped_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_idx > LAST_IDX)) |=> $stable(cfg_flat));

endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cs_s,
  input  logic              sdio_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdio_out,
  output logic              sdio_oe
);

  localparam int INSTR_W = ADDR_W + 3;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DATA_W - 1);

  phase_e             phase;
  logic               cs_q;
  logic [CNT_W-1:0]   cnt;
  logic [INSTR_W-2:0] instr_sh;
  logic               is_read;
  logic [1:0]         len;
  logic [ADDR_W-1:0]  addr;
  logic [1:0]         byte_idx;
  logic [DATA_W-2:0]  rx_sh;
  logic [DATA_W-1:0]  tx_sh;

  logic [INSTR_W-1:0] full_instr;
  logic               instr_done, byte_done, last_byte;
  logic [ADDR_W-1:0]  addr_nxt;

  assign full_instr = {instr_sh, sdio_s};
  assign instr_done = (phase == PH_INSTR) && sclk_rise && (cnt == INSTR_LAST);
  assign byte_done  = (phase == PH_DATA)  && sclk_rise && (cnt == BYTE_LAST);
  assign last_byte  = (len != LEN_STREAM) && (byte_idx == len);
  assign addr_nxt   = instr_done ? full_instr[ADDR_W-1:0] : addr - 1'b1;
  // look-ahead address: the byte fetched is ready as the next one starts
  assign rd_addr    = addr_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cs_q     <= 1'b1;
      cnt      <= '0;
      instr_sh <= '0;
      is_read  <= 1'b0;
      len      <= '0;
      addr     <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      cs_q     <= cs_s;
      wr_valid <= 1'b0;
      if (!enable || cs_s) begin
        // abort or idle: drop everything held for the frame
        phase    <= PH_IDLE;
        cnt      <= '0;
        sdio_oe  <= 1'b0;
        sdio_out <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            if (cs_q) begin
              phase <= PH_INSTR;
              cnt   <= '0;
            end
          end
          PH_INSTR: begin
            if (sclk_rise) begin
              instr_sh <= full_instr[INSTR_W-2:0];
              cnt      <= cnt + 1'b1;
              if (instr_done) begin
                is_read  <= full_instr[INSTR_W-1];
                len      <= full_instr[INSTR_W-2 -: 2];
                addr     <= addr_nxt;
                tx_sh    <= rd_data;
                byte_idx <= '0;
                cnt      <= '0;
                phase    <= PH_DATA;
              end
            end
          end
          PH_DATA: begin
            if (sclk_fall && is_read) begin
              sdio_oe  <= 1'b1;
              sdio_out <= tx_sh[DATA_W-1];
              tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (sclk_rise) begin
              rx_sh <= {rx_sh[DATA_W-3:0], sdio_s};
              cnt   <= cnt + 1'b1;
              if (byte_done) begin
                cnt      <= '0;
                addr     <= addr_nxt;
                tx_sh    <= rd_data;
                byte_idx <= byte_idx + 1'b1;
                if (!is_read) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= addr;
                  wr_data  <= {rx_sh, sdio_s};
                end
                if (last_byte) begin
                  phase    <= PH_DONE;
                  sdio_oe  <= 1'b0;
                  sdio_out <= 1'b0;
                end
              end
            end
          end
          default: ; // PH_DONE: further clocks ignored until select rises
        endcase
      end
    end
  end

  // R6: driving starts only on a synchronized falling edge
  p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall));

  // R6: the line is never driven in a write frame
  p_no_drive_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (is_read && phase == PH_DATA));

  // R7: release happens on a rising edge or by abort
  p_release_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdio_oe) |-> $past(sclk_rise || cs_s || !enable));

  // R8: a raised select clears the frame on the next cycle
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!sdio_oe && phase == PH_IDLE && cnt == '0));

  // R2: a byte is handed to the bank only right after a sampling edge
  p_write_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(sclk_rise && !cs_s));

endmodule

// File: rtl/spi3_regport.sv
module spi3_regport
  import spi3_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_BASE = 0,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_cs_n,
  input  logic                       spi_sclk,
  input  logic                       spi_sdio_i,
  output logic                       spi_sdio_o,
  output logic                       spi_sdio_oe,
  output logic                       strap_mode,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

  localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1 << PIN_CS);
  localparam int               SETTLE  = 2;

  logic [PIN_N-1:0] pins, pin_s, pin_p;
  logic             cs_s, sclk_rise, sclk_fall;
  logic [1:0]       settle;
  logic             decided, enable;

  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  assign pins[PIN_CS]   = spi_cs_n;
  assign pins[PIN_SCLK] = spi_sclk;
  assign pins[PIN_SDIO] = spi_sdio_i;

  spi3_pinsync #(.W(PIN_N), .RST_VAL(PIN_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pins),
    .sync_o (pin_s),
    .prev_o (pin_p)
  );

  assign cs_s      = pin_s[PIN_CS];
  assign sclk_rise =  pin_s[PIN_SCLK] & ~pin_p[PIN_SCLK];
  assign sclk_fall = ~pin_s[PIN_SCLK] &  pin_p[PIN_SCLK];

  // strap decision: taken once the synchronizer holds the pin level at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle     <= '0;
      decided    <= 1'b0;
      strap_mode <= 1'b0;
    end else if (!decided) begin
      if (settle == 2'(SETTLE)) begin
        decided    <= 1'b1;
        strap_mode <= cs_s;
      end else begin
        settle <= settle + 1'b1;
      end
    end
  end

  assign enable = decided && !strap_mode;

  spi3_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cs_s      (cs_s),
    .sdio_s    (pin_s[PIN_SDIO]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdio_out  (spi_sdio_o),
    .sdio_oe   (spi_sdio_oe)
  );

  spi3_regbank #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE     (REG_BASE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_flat (cfg_regs)
  );

  // R10: strap mode never drives the data line
  p_strap_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strap_mode |-> !spi_sdio_oe);

  // R10: once taken, the strap decision holds until reset
  p_strap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && $past(decided)) |-> $stable(strap_mode));

endmodule

// File: tb/tb_spi3_regport.sv
module tb_spi3_regport;
  localparam int NREG = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cs_n, sclk, sdio_in;
  logic sdio_out, sdio_oe, strap_mode;
  logic [NREG*8-1:0] cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mdl  [NREG];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] obuf [8];
  int         instr_oe;

  spi3_regport #(.NUM_REGS(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_sdio_i(sdio_in), .spi_sdio_o(sdio_out), .spi_sdio_oe(sdio_oe),
    .strap_mode(strap_mode), .cfg_regs(cfg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [12:0] a);
    return (a < NREG) ? mdl[a] : 8'h00;
  endfunction

  function automatic int eff_bytes(input logic [1:0] len, input int clocked);
    int n;
    n = (len == 2'b11) ? clocked : int'(len) + 1;
    return (n < clocked) ? n : clocked;
  endfunction

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  task automatic chk_cfg(input string req);
    chk(cfg === model_flat(), req, "register bus", cfg, model_flat());
  endtask

  // one serial bit: low phase with data set up, sample output, then high phase
  task automatic sbit(input logic b, output logic got, output logic oe_seen);
    sclk = 1'b0;
    sdio_in = b;
    tick(4);
    got = sdio_out;
    oe_seen = sdio_oe;
    sclk = 1'b1;
    tick(4);
  endtask

  task automatic xfer(input logic rw, input logic [1:0] len, input logic [12:0] addr,
                      input int nbits);
    logic [15:0] ins;
    logic g, o;
    ins = {rw, len, addr};
    instr_oe = 0;
    cs_n = 1'b0;
    tick(4);
    for (int i = 15; i >= 0; i--) begin
      sbit(ins[i], g, o);
      if (o) instr_oe++;
    end
    for (int k = 0; k < nbits; k++) begin
      sbit(rw ? 1'b0 : wbuf[k/8][7-(k%8)], g, o);
      rbuf[k/8][7-(k%8)] = g;
      obuf[k/8][7-(k%8)] = o;
    end
  endtask

  task automatic end_frame();
    cs_n = 1'b1;
    sclk = 1'b0;
    tick(6);
  endtask

  task automatic model_write(input logic [1:0] len, input logic [12:0] addr, input int clocked);
    logic [12:0] a;
    a = addr;
    for (int j = 0; j < eff_bytes(len, clocked); j++) begin
      if (a < NREG) mdl[a] = wbuf[j];
      a = a - 13'd1;
    end
  endtask

  task automatic chk_read(input logic [1:0] len, input logic [12:0] addr, input int clocked,
                          input string req);
    logic [12:0] a;
    a = addr;
    for (int j = 0; j < eff_bytes(len, clocked); j++) begin
      chk(rbuf[j] === model_rd(a), req, "read byte", rbuf[j], model_rd(a));
      chk(obuf[j] === 8'hff, "R6", "enable during read byte", obuf[j], 8'hff);
      a = a - 13'd1;
    end
  endtask

  task automatic do_reset(input logic cs_level);
    rst_n = 1'b0;
    cs_n = cs_level;
    sclk = 1'b0;
    sdio_in = 1'b0;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(8);
    cs_n = 1'b1;
    tick(6);
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic rw;
    logic [1:0] len;
    logic [12:0] addr;
    int nb;
    void'($urandom(32'd4711));

    // R11: reset state with select low at release
    do_reset(1'b0);
    chk(cfg === '0, "R11", "registers after reset", cfg, 0);
    chk(sdio_oe === 1'b0, "R11", "enable after reset", sdio_oe, 0);
    chk(strap_mode === 1'b0, "R11", "strap flag", strap_mode, 0);

    // R1 R3: one-byte write clocked with a spare byte
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    xfer(1'b0, 2'b00, 13'd3, 16);
    chk(instr_oe == 0, "R6", "enable during write instruction", instr_oe, 0);
    end_frame();
    model_write(2'b00, 13'd3, 2);
    chk_cfg("R3");

    // R5: three-byte write walks downward
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(1'b0, 2'b10, 13'd5, 24);
    end_frame();
    model_write(2'b10, 13'd5, 3);
    chk_cfg("R5");

    // R6 R7: three-byte read, released after the last rising edge
    xfer(1'b1, 2'b10, 13'd5, 24);
    chk(instr_oe == 0, "R6", "enable during read instruction", instr_oe, 0);
    chk(sdio_oe === 1'b0, "R7", "enable after last byte", sdio_oe, 0);
    end_frame();
    chk_read(2'b10, 13'd5, 3, "R6");

    // R4 R9 R5: streaming write across address zero into unmapped space
    for (int j = 0; j < 5; j++) wbuf[j] = 8'hC0 + 8'(j);
    xfer(1'b0, 2'b11, 13'd2, 40);
    end_frame();
    model_write(2'b11, 13'd2, 5);
    chk_cfg("R4");

    // R4 R8: streaming read keeps driving until select rises
    xfer(1'b1, 2'b11, 13'd1, 32);
    chk(sdio_oe === 1'b1, "R4", "enable still on while streaming", sdio_oe, 1);
    end_frame();
    chk(sdio_oe === 1'b0, "R8", "enable after select rise", sdio_oe, 0);
    chk_read(2'b11, 13'd1, 4, "R4");

    // R8 R2: partial write byte discarded
    wbuf[0] = 8'hFF;
    xfer(1'b0, 2'b00, 13'd6, 5);
    end_frame();
    chk_cfg("R8");

    // R9: unmapped read returns zero, unmapped write ignored
    xfer(1'b1, 2'b01, 13'd100, 16);
    end_frame();
    chk_read(2'b01, 13'd100, 2, "R9");
    wbuf[0] = 8'h77;
    xfer(1'b0, 2'b00, 13'd200, 8);
    end_frame();
    chk_cfg("R9");

    // R8: abort in mid-instruction, then a normal write succeeds
    begin
      logic g, o;
      cs_n = 1'b0; tick(4);
      for (int i = 0; i < 7; i++) sbit(1'b1, g, o);
      end_frame();
    end
    wbuf[0] = 8'h3C;
    xfer(1'b0, 2'b00, 13'd7, 8);
    end_frame();
    model_write(2'b00, 13'd7, 1);
    chk_cfg("R8");

    // random frames, R1 R2 R5 R6 R7 R9
    for (int n = 0; n < 40; n++) begin
      rw = 1'($urandom % 2);
      len = 2'($urandom % 4);
      addr = 13'($urandom % (NREG + 4));
      if (len == 2'b11) nb = 1 + int'($urandom % 5);
      else nb = int'(len) + 1 + ((!rw && ($urandom % 4 == 0)) ? 1 : 0);
      for (int j = 0; j < 8; j++) wbuf[j] = 8'($urandom);
      xfer(rw, len, addr, nb * 8);
      chk(instr_oe == 0, "R6", "enable during instruction", instr_oe, 0);
      if (rw && len != 2'b11)
        chk(sdio_oe === 1'b0, "R7", "enable after final byte", sdio_oe, 0);
      end_frame();
      if (rw) chk_read(len, addr, nb, "R1");
      else begin
        model_write(len, addr, nb);
        chk_cfg("R2");
      end
    end

    // R10: select high at reset release puts the port in strap mode
    do_reset(1'b1);
    chk(strap_mode === 1'b1, "R10", "strap flag", strap_mode, 1);
    wbuf[0] = 8'hEE;
    xfer(1'b0, 2'b00, 13'd0, 8);
    end_frame();
    chk(cfg === '0, "R10", "registers in strap mode", cfg, 0);
    xfer(1'b1, 2'b00, 13'd0, 8);
    chk(obuf[0] === 8'h00 && instr_oe == 0, "R10", "enable in strap mode", obuf[0], 0);
    end_frame();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule